// File: doc/BRIEF.md
# Vectoring Interrupt Controller with Call Injection

This block collects interrupt events from several source lines and presents one request to an 8-bit CPU. The CPU answers with an acknowledge handshake. It then fetches the interrupt instruction with a qualifier held high and one or more read strobes. While the qualifier and a read are both active, the controller places instruction bytes on the CPU data bus, and the CPU executes them as if they came from memory.

The controller has two modes. In restart mode it answers with one byte: a restart opcode that selects one of eight fixed vector slots. In call mode it answers with three bytes over three reads: a CALL opcode, then the low byte of the target, then the high byte. The target is a programmable 16-bit base plus the winning source index times four. A CPU can therefore vector to any address in its space. The mask and base values come from registers held outside this block.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a cycle with `rstN` low, no event is pending, the stage is the opcode stage, and `cpuIntReq` and `dataOe` are low.
- R2: `cpuIntReq` is high while at least one unmasked event is pending and the CPU is not in service. A cycle with `cpuIntAck` high puts the CPU in service from the next cycle on. Service ends in the cycle after `intFetch` falls.
- R3: A rising edge on `srcReq[i]` sets the pending flag for source i. A level that is held high does not set the flag again.
- R4: When several unmasked events are pending, the lowest source index is served first.
- R5: `dataOe` is high only in cycles where `intFetch` and `rdStrobe` are both high. In all other cycles `dataOut` is 8'h00.
- R6: In restart mode (`callMode`=0), the single byte is 8'b11_nnn_111, where nnn is the winning index.
- R7: In call mode, successive reads return 8'hCD, then the low byte of `vecBase + 4*index`, then the high byte of that sum, with carry across the bytes.
- R8: The winner's pending flag clears when the first byte of its fetch is delivered, so the next event is served next.
- R9: When `intFetch` falls, the byte stage returns to the opcode stage even if fewer than three bytes were read.
- R10: A mask bit of 1 (`irqMask[i]`) keeps source i from requesting and from winning. Its events are still captured and are served once the bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| srcReq | input | NUM_SRC | Interrupt source lines, edge-captured |
| irqMask | input | NUM_SRC | Per-source mask, 1 = blocked |
| vecBase | input | 16 | Base address for call-mode targets |
| callMode | input | 1 | 0 = restart byte, 1 = three-byte CALL |
| cpuIntReq | output | 1 | Interrupt request to the CPU |
| cpuIntAck | input | 1 | Acknowledge from the CPU |
| intFetch | input | 1 | CPU is fetching the interrupt instruction |
| rdStrobe | input | 1 | CPU read, one cycle per byte |
| dataOut | output | 8 | Instruction byte for the CPU data bus |
| dataOe | output | 1 | Drive enable for `dataOut` |

## Verification
The bench builds the block with the default eight sources and a stride of four bytes. Eight sources let one run reach every restart slot encoding, including index values above three. A stride of four with a base of 8'hFC in the low byte pushes the target across a high-byte boundary, so the carry into the third CALL byte is checked. A reference model in the bench tracks the pending set, the service flag and the byte stage, and it compares all three outputs on every clock. The stimulus covers simultaneous events, masking and later unmasking, idle cycles between reads, and a fetch that is cut short after its opcode.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
  localparam logic [7:0] CALL_OPCODE = 8'hCD;

  typedef enum logic [1:0] {
    STG_OPCODE = 2'd0,
    STG_LOW    = 2'd1,
    STG_HIGH   = 2'd2
  } byteStage_e;

  typedef struct packed {
    logic       drive;
    logic       takeWinner;
    byteStage_e stage;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_vector_dp.sv
module irq_vector_dp
  import irq_vector_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] irqMask,
  input  logic [15:0]        vecBase,
  input  logic               callMode,
  input  ctrlStrobes_t       strobes,
  output logic               anyCand,
  output logic [7:0]         dataOut
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] pending, srcPrev, cand, risen, clrMask;
  logic [IDX_W-1:0]   winIdx, curIdx;
  logic [15:0]        target;
  logic [2:0]         slot;

  assign risen = srcReq & ~srcPrev;
  assign cand  = pending & ~irqMask;
  assign anyCand = |cand;

  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i]) winIdx = IDX_W'(i);
    end
  end

  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : gClr
      assign clrMask[g] = strobes.takeWinner && anyCand && (winIdx == IDX_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      srcPrev <= '0;
      curIdx  <= '0;
    end else begin
      srcPrev <= srcReq;
      pending <= (pending & ~clrMask) | risen;
      if (strobes.takeWinner) curIdx <= winIdx;
    end
  end

  assign target = vecBase + (16'(curIdx) << STRIDE_LOG2);
  assign slot   = 3'(winIdx);

  always_comb begin
    dataOut = 8'h00;
    if (strobes.drive) begin
      unique case (strobes.stage)
        STG_OPCODE: dataOut = callMode ? CALL_OPCODE : {2'b11, slot, 3'b111};
        STG_LOW:    dataOut = target[7:0];
        STG_HIGH:   dataOut = target[15:8];
        default:    dataOut = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/irq_vector_ctl.sv
module irq_vector_ctl
  import irq_vector_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         callMode,
  input  logic         anyCand,
  input  logic         cpuIntAck,
  input  logic         intFetch,
  input  logic         rdStrobe,
  output logic         cpuIntReq,
  output ctrlStrobes_t strobes
);
  byteStage_e stage;
  logic       inService, fetchPrev, fetchRd;

  assign fetchRd = intFetch && rdStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage     <= STG_OPCODE;
      inService <= 1'b0;
      fetchPrev <= 1'b0;
    end else begin
      fetchPrev <= intFetch;
      if (cpuIntAck) inService <= 1'b1;
      else if (fetchPrev && !intFetch) inService <= 1'b0;
      if (!intFetch) stage <= STG_OPCODE;
      else if (rdStrobe) begin
        if (callMode && stage == STG_OPCODE) stage <= STG_LOW;
        else if (callMode && stage == STG_LOW) stage <= STG_HIGH;
        else stage <= STG_OPCODE;
      end
    end
  end

  assign cpuIntReq          = anyCand && !inService;
  assign strobes.drive      = fetchRd;
  assign strobes.takeWinner = fetchRd && (stage == STG_OPCODE);
  assign strobes.stage      = stage;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STRIDE_LOG2 = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] irqMask,
  input  logic [15:0]        vecBase,
  input  logic               callMode,
  output logic               cpuIntReq,
  input  logic               cpuIntAck,
  input  logic               intFetch,
  input  logic               rdStrobe,
  output logic [7:0]         dataOut,
  output logic               dataOe
);
  ctrlStrobes_t strobes;
  logic         anyCand;

  irq_vector_ctl uCtl (
    .clk(clk), .rstN(rstN), .callMode(callMode), .anyCand(anyCand),
    .cpuIntAck(cpuIntAck), .intFetch(intFetch), .rdStrobe(rdStrobe),
    .cpuIntReq(cpuIntReq), .strobes(strobes)
  );

  irq_vector_dp #(.NUM_SRC(NUM_SRC), .STRIDE_LOG2(STRIDE_LOG2)) uDp (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .irqMask(irqMask),
    .vecBase(vecBase), .callMode(callMode), .strobes(strobes),
    .anyCand(anyCand), .dataOut(dataOut)
  );

  assign dataOe = strobes.drive;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       callMode,
  input logic       cpuIntReq,
  input logic       cpuIntAck,
  input logic       intFetch,
  input logic [7:0] dataOut,
  input logic       dataOe
);
  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rstN |=> (!cpuIntReq && !dataOe));

  a_r2_req_drops_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    cpuIntAck |=> !cpuIntReq);

  a_r5_quiet_outside_fetch: assert property (@(posedge clk) disable iff (!rstN)
    !intFetch |-> (!dataOe && dataOut == 8'h00));

  a_r6_restart_shape: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && !callMode) |-> (dataOut[7:6] == 2'b11 && dataOut[2:0] == 3'b111));

  a_r9_opcode_leads: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && callMode && $past(rstN) && !$past(intFetch)) |-> dataOut == 8'hCD);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk uChk (
  .clk(clk), .rstN(rstN), .callMode(callMode), .cpuIntReq(cpuIntReq),
  .cpuIntAck(cpuIntAck), .intFetch(intFetch), .dataOut(dataOut), .dataOe(dataOe)
);

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] srcReq = '0;
  logic [N-1:0] irqMask = '0;
  logic [15:0]  vecBase = 16'h0000;
  logic         callMode = 1'b0;
  logic         cpuIntAck = 1'b0;
  logic         intFetch = 1'b0;
  logic         rdStrobe = 1'b0;
  logic         cpuIntReq, dataOe;
  logic [7:0]   dataOut;

  int    tests = 0;
  int    fails = 0;
  string tag = "R1";

  // reference model state
  bit [N-1:0] mPend = '0;
  bit [N-1:0] mPrev = '0;
  int         mStage = 0;
  int         mCur = 0;
  bit         mSvc = 0;
  bit         mFetchPrev = 0;

  always #10 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .irqMask(irqMask),
    .vecBase(vecBase), .callMode(callMode), .cpuIntReq(cpuIntReq),
    .cpuIntAck(cpuIntAck), .intFetch(intFetch), .rdStrobe(rdStrobe),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  function automatic int winner();
    for (int i = 0; i < N; i++) if (mPend[i] && !irqMask[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // compare mid low phase, after inputs driven at negedge
  always @(negedge clk) begin
    #5;
    if (rstN) begin
      int w;
      bit eReq, eOe;
      int eData;
      int addr;
      w = winner();
      eReq = (w >= 0) && !mSvc;
      eOe = intFetch && rdStrobe;
      eData = 0;
      addr = (vecBase + mCur * 4) & 16'hFFFF;
      if (eOe) begin
        if (mStage == 0) eData = callMode ? 8'hCD : (8'hC7 | ((w < 0 ? 0 : w) << 3));
        else if (mStage == 1) eData = addr & 8'hFF;
        else eData = addr >> 8;
      end
      check(cpuIntReq == eReq, "cpuIntReq", cpuIntReq, eReq);
      check(dataOe == eOe, "dataOe", dataOe, eOe);
      check(dataOut == 8'(eData), "dataOut", dataOut, eData);
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mPend = '0; mPrev = '0; mStage = 0; mCur = 0; mSvc = 0; mFetchPrev = 0;
    end else begin
      int w;
      w = winner();
      if (intFetch && rdStrobe && mStage == 0) begin
        mCur = (w < 0) ? 0 : w;
        if (w >= 0) mPend[w] = 1'b0;
      end
      mPend = mPend | (srcReq & ~mPrev);
      mPrev = srcReq;
      if (cpuIntAck) mSvc = 1;
      else if (mFetchPrev && !intFetch) mSvc = 0;
      mFetchPrev = intFetch;
      if (!intFetch) mStage = 0;
      else if (rdStrobe) mStage = (callMode && mStage < 2) ? mStage + 1 : 0;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    srcReq[idx] = 1'b1; step(1);
    srcReq[idx] = 1'b0; step(1);
  endtask

  task automatic serve(input int reads);
    cpuIntAck = 1'b1; step(1);
    cpuIntAck = 1'b0; intFetch = 1'b1; step(1);
    for (int r = 0; r < reads; r++) begin
      rdStrobe = 1'b1; step(1);
      rdStrobe = 1'b0; step(1);
    end
    intFetch = 1'b0; step(2);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    #5;
    tag = "R1";
    check(!cpuIntReq && !dataOe && dataOut == 8'h00, "reset state", {cpuIntReq, dataOe}, 0);
    step(1);

    // R3 edge capture, R4 priority, R6 restart bytes, R8 clear on first byte
    tag = "R4";
    srcReq[5] = 1'b1; srcReq[3] = 1'b1; step(1);
    tag = "R3"; step(3);              // held high: captured only once
    srcReq[5] = 1'b0; srcReq[3] = 1'b0; step(1);
    tag = "R6"; serve(1);             // expect 8'hDF
    tag = "R8"; step(1);              // source 5 still requests
    tag = "R6"; serve(1);             // expect 8'hEF
    tag = "R2"; step(2);              // nothing left: request low

    // R5 read strobes without the fetch qualifier
    tag = "R5";
    pulse(7);
    for (int k = 0; k < 6; k++) begin
      rdStrobe = k[0]; step(1);
    end
    rdStrobe = 1'b0;
    serve(1);                         // expect 8'hFF

    // R10 masking, R7 full CALL
    tag = "R10";
    irqMask = 8'h04;
    pulse(2); step(3);
    pulse(0); step(1);
    irqMask = 8'h00; step(2);
    tag = "R7";
    callMode = 1'b1; vecBase = 16'h1234;
    serve(3);                         // source 0: CD 34 12
    serve(3);                         // source 2: CD 3C 12

    // R9 truncated fetch, carry across bytes
    tag = "R9";
    vecBase = 16'h10FC;
    pulse(1);
    serve(1);
    pulse(1);
    tag = "R7";
    serve(3);                         // CD 00 11
    tag = "R2";
    pulse(6); pulse(4);
    serve(3);
    serve(3);
    step(3);
    summary();
  end
endmodule